// File: doc/BRIEF.md
# Triggered Format String Sequencer

This block turns a stored print program into a byte stream whenever a trigger condition is met. The program is a small memory of pre-decoded entries: literal characters, field entries (with a bit size and an opaque option word for a downstream numeric formatter), and an end marker. When a print starts, the argument vector is copied into a shadow register. The sequencer then walks the program from address zero. Literal characters go straight to the byte output. Each field entry is handed to an external formatter together with the next argument slice, and the formatter's characters are forwarded to the same output until it flags its last one.

A print starts in one of two ways, chosen by a parameter. In edge mode, each trigger bit has its own polarity bit, and any bit that sees its selected edge starts a print. In free-running mode, a print starts on every clock in which the block is idle. In both modes the enable input must be high. Doubled braces in the program collapse to a single brace. A start condition that occurs while a print is running is discarded, and a busy flag shows when a print is in progress.

Top module: `fmt_print_seq`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `busy`, `out_valid`, `fld_valid` and `done` are all low.
- R2: With `TRG_EN`=1, a trigger bit whose `TRG_POL` bit is 1 starts a print on a 0-to-1 change, and one whose polarity bit is 0 starts a print on a 1-to-0 change. Edges of the opposite direction start nothing. `busy` rises at the clock edge that first samples the new trigger value.
- R3: With `TRG_EN`=0, a new print starts at every clock edge where the block is idle and `en` is high.
- R4: No print starts while `en` is low.
- R5: A start condition that occurs while `busy` is high is discarded. It is not queued.
- R6: Literal entries (kind code 1) are sent on `out_data` in program order. `out_valid` and `out_data` are held until `out_ready` is high.
- R7: A literal entry holding 0x7B or 0x7D emits that one brace and also consumes the entry that follows it.
- R8: A field entry (kind code 2) presents its size, its option word and its argument value on the field port. Values are taken from the argument vector starting at bit 0, with each field taking the next `size` bits in program order, and all bits above `size` are zero. These outputs are held until `fld_ready` is high.
- R9: After a field is accepted, the formatter's bytes are passed to the output, each under the output handshake, until the byte marked last has been accepted. The sequence then resumes at the next entry.
- R10: Field values come from the argument vector as it was at the start of the print, even if `args` changes later.
- R11: A print ends at an entry of kind 0 or 3, or once the address moves past the last memory entry. `done` then pulses high for one cycle with `busy` already low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Enable for the whole block |
| trig | input | TRG_W | Trigger vector |
| args | input | ARGS_W | Packed argument values, first field at bit 0 |
| fmt_addr | output | AW | Program memory read address |
| fmt_kind | input | 2 | Entry kind: 0 end, 1 literal, 2 field, 3 end |
| fmt_char | input | 8 | Literal character of the entry |
| fmt_size | input | SZ_W | Field size in bits |
| fmt_spec | input | SP_W | Field option word for the formatter |
| fld_valid | output | 1 | Field request valid |
| fld_ready | input | 1 | Formatter accepts the request |
| fld_size | output | SZ_W | Field size of the request |
| fld_spec | output | SP_W | Field option word of the request |
| fld_value | output | FV_W | Argument slice of the request |
| fx_valid | input | 1 | Formatter byte valid |
| fx_data | input | 8 | Formatter byte |
| fx_last | input | 1 | Formatter byte is the last of the field |
| fx_ready | output | 1 | Formatter byte accepted |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Output byte |
| out_ready | input | 1 | Sink accepts the output byte |
| busy | output | 1 | Print in progress |
| done | output | 1 | One-cycle pulse after the end of a print |

## Verification
Directed programs drive one trigger bit of each polarity through both edge directions, so a swapped polarity or a level-sensitive trigger is caught. Fixed field layouts with known argument bits check the slicing order and the masking. Brace pairs, a program with no end marker, argument changes during a print, and extra trigger edges while busy each cover one specific path that could go wrong. Seeded random programs that mix literals, fields of 1 to 32 bits and brace pairs are run under random back-pressure on both handshakes, and the output bytes are compared with a string built in the bench. A second instance in free-running mode is used to show that prints repeat back to back and stop when the enable goes low.

// File: rtl/fseq_pkg.sv
package fseq_pkg;

  typedef enum logic [1:0] {
    ENT_END   = 2'd0,
    ENT_CHAR  = 2'd1,
    ENT_FIELD = 2'd2,
    ENT_STOP  = 2'd3
  } ent_kind_e;

  typedef enum logic [2:0] {
    S_IDLE   = 3'd0,
    S_FETCH  = 3'd1,
    S_EMIT   = 3'd2,
    S_FREQ   = 3'd3,
    S_STREAM = 3'd4
  } seq_state_e;

  localparam logic [7:0] CH_LBRACE = 8'h7B;
  localparam logic [7:0] CH_RBRACE = 8'h7D;

endpackage

// File: rtl/fseq_trigger.sv
module fseq_trigger #(
  parameter int unsigned    TRG_W   = 3,
  parameter bit             TRG_EN  = 1'b1,
  parameter logic [TRG_W-1:0] TRG_POL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [TRG_W-1:0] trig,
  output logic             fire
);

  generate
    if (TRG_EN) begin : g_edge
      logic [TRG_W-1:0] prev_q;
      logic [TRG_W-1:0] hit;

      for (genvar b = 0; b < TRG_W; b++) begin : g_bit
        if (TRG_POL[b]) begin : g_rise
          assign hit[b] = trig[b] & ~prev_q[b];
        end else begin : g_fall
          assign hit[b] = ~trig[b] & prev_q[b];
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= trig;
      end

      assign fire = en & (|hit);
    end else begin : g_free
      logic unused_in;
      assign unused_in = clk ^ rst_n ^ (^trig);
      assign fire      = en;
    end
  endgenerate

endmodule

// File: rtl/fseq_args.sv
module fseq_args #(
  parameter int unsigned ARGS_W = 64,
  parameter int unsigned FV_W   = 32,
  parameter int unsigned SZ_W   = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ARGS_W-1:0] args,
  input  logic              consume,
  input  logic [SZ_W-1:0]   size,
  output logic [FV_W-1:0]   value
);

  logic [ARGS_W-1:0] shadow_q;
  logic [ARGS_W-1:0] shadow_d;
  logic [FV_W:0]     ones_ext;
  logic [FV_W-1:0]   mask;

  always_comb begin
    ones_ext = ({{FV_W{1'b0}}, 1'b1} << size) - 1'b1;
    if (32'(size) >= FV_W) mask = '1;
    else                   mask = ones_ext[FV_W-1:0];
  end

  assign value = shadow_q[FV_W-1:0] & mask;

  always_comb begin
    shadow_d = shadow_q;
    if (load)         shadow_d = args;
    else if (consume) shadow_d = shadow_q >> size;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              shadow_q <= '0;
    else if (load | consume) shadow_q <= shadow_d;
  end

endmodule

// File: rtl/fseq_ctrl.sv
module fseq_ctrl
  import fseq_pkg::*;
#(
  parameter int unsigned AW   = 5,
  parameter int unsigned SZ_W = 6,
  parameter int unsigned SP_W = 8,
  parameter int unsigned FV_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fire,
  output logic [AW-1:0]   fmt_addr,
  input  logic [1:0]      fmt_kind,
  input  logic [7:0]      fmt_char,
  input  logic [SZ_W-1:0] fmt_size,
  input  logic [SP_W-1:0] fmt_spec,
  output logic            shadow_load,
  output logic            shadow_consume,
  input  logic [FV_W-1:0] arg_value,
  output logic            fld_valid,
  input  logic            fld_ready,
  output logic [SZ_W-1:0] fld_size,
  output logic [SP_W-1:0] fld_spec,
  output logic [FV_W-1:0] fld_value,
  input  logic            fx_valid,
  input  logic [7:0]      fx_data,
  input  logic            fx_last,
  output logic            fx_ready,
  output logic            out_valid,
  output logic [7:0]      out_data,
  input  logic            out_ready,
  output logic            busy,
  output logic            done
);

  localparam int unsigned PW = AW + 1;
  localparam logic [PW-1:0] STEP1 = PW'(1);
  localparam logic [PW-1:0] STEP2 = PW'(2);

  seq_state_e      state_q, state_d;
  logic [PW-1:0]   ptr_q, ptr_d;
  logic [7:0]      chr_q, chr_d;
  logic [SZ_W-1:0] fsz_q, fsz_d;
  logic [SP_W-1:0] fsp_q, fsp_d;
  logic [FV_W-1:0] fvl_q, fvl_d;
  logic            done_q, done_d;
  logic            is_brace;
  logic            at_end;

  assign is_brace = (fmt_char == CH_LBRACE) || (fmt_char == CH_RBRACE);
  assign at_end   = ptr_q[AW] || (fmt_kind == ENT_END) || (fmt_kind == ENT_STOP);

  always_comb begin
    state_d        = state_q;
    ptr_d          = ptr_q;
    chr_d          = chr_q;
    fsz_d          = fsz_q;
    fsp_d          = fsp_q;
    fvl_d          = fvl_q;
    done_d         = 1'b0;
    shadow_load    = 1'b0;
    shadow_consume = 1'b0;
    unique case (state_q)
      S_IDLE: begin
        if (fire) begin
          shadow_load = 1'b1;
          ptr_d       = '0;
          state_d     = S_FETCH;
        end
      end
      S_FETCH: begin
        if (at_end) begin
          done_d  = 1'b1;
          state_d = S_IDLE;
        end else if (fmt_kind == ENT_CHAR) begin
          chr_d   = fmt_char;
          ptr_d   = ptr_q + (is_brace ? STEP2 : STEP1);
          state_d = S_EMIT;
        end else begin
          fsz_d          = fmt_size;
          fsp_d          = fmt_spec;
          fvl_d          = arg_value;
          shadow_consume = 1'b1;
          ptr_d          = ptr_q + STEP1;
          state_d        = S_FREQ;
        end
      end
      S_EMIT: begin
        if (out_ready) state_d = S_FETCH;
      end
      S_FREQ: begin
        if (fld_ready) state_d = S_STREAM;
      end
      S_STREAM: begin
        if (fx_valid && out_ready && fx_last) state_d = S_FETCH;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      ptr_q   <= '0;
      chr_q   <= '0;
      fsz_q   <= '0;
      fsp_q   <= '0;
      fvl_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      ptr_q   <= ptr_d;
      done_q  <= done_d;
      if (state_q == S_FETCH) begin
        chr_q <= chr_d;
        fsz_q <= fsz_d;
        fsp_q <= fsp_d;
        fvl_q <= fvl_d;
      end
    end
  end

  assign fmt_addr  = ptr_q[AW-1:0];
  assign busy      = (state_q != S_IDLE);
  assign done      = done_q;
  assign fld_valid = (state_q == S_FREQ);
  assign fld_size  = fsz_q;
  assign fld_spec  = fsp_q;
  assign fld_value = fvl_q;
  assign fx_ready  = (state_q == S_STREAM) && out_ready;
  assign out_valid = (state_q == S_EMIT) || ((state_q == S_STREAM) && fx_valid);
  assign out_data  = (state_q == S_STREAM) ? fx_data : chr_q;

endmodule

// File: rtl/fmt_print_seq.sv
module fmt_print_seq #(
  parameter int unsigned      TRG_W   = 3,
  parameter bit               TRG_EN  = 1'b1,
  parameter logic [TRG_W-1:0] TRG_POL = 3'b101,
  parameter int unsigned      ARGS_W  = 64,
  parameter int unsigned      AW      = 5,
  parameter int unsigned      SZ_W    = 6,
  parameter int unsigned      SP_W    = 8,
  parameter int unsigned      FV_W    = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [TRG_W-1:0]  trig,
  input  logic [ARGS_W-1:0] args,
  output logic [AW-1:0]     fmt_addr,
  input  logic [1:0]        fmt_kind,
  input  logic [7:0]        fmt_char,
  input  logic [SZ_W-1:0]   fmt_size,
  input  logic [SP_W-1:0]   fmt_spec,
  output logic              fld_valid,
  input  logic              fld_ready,
  output logic [SZ_W-1:0]   fld_size,
  output logic [SP_W-1:0]   fld_spec,
  output logic [FV_W-1:0]   fld_value,
  input  logic              fx_valid,
  input  logic [7:0]        fx_data,
  input  logic              fx_last,
  output logic              fx_ready,
  output logic              out_valid,
  output logic [7:0]        out_data,
  input  logic              out_ready,
  output logic              busy,
  output logic              done
);

  logic            fire;
  logic            start_ok;
  logic            shadow_load;
  logic            shadow_consume;
  logic [FV_W-1:0] arg_value;

  fseq_trigger #(
    .TRG_W  (TRG_W),
    .TRG_EN (TRG_EN),
    .TRG_POL(TRG_POL)
  ) trig_i (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (en),
    .trig (trig),
    .fire (fire)
  );

  assign start_ok = fire & ~busy;

  fseq_args #(
    .ARGS_W(ARGS_W),
    .FV_W  (FV_W),
    .SZ_W  (SZ_W)
  ) args_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (shadow_load),
    .args   (args),
    .consume(shadow_consume),
    .size   (fmt_size),
    .value  (arg_value)
  );

  fseq_ctrl #(
    .AW  (AW),
    .SZ_W(SZ_W),
    .SP_W(SP_W),
    .FV_W(FV_W)
  ) ctrl_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .fire          (start_ok),
    .fmt_addr      (fmt_addr),
    .fmt_kind      (fmt_kind),
    .fmt_char      (fmt_char),
    .fmt_size      (fmt_size),
    .fmt_spec      (fmt_spec),
    .shadow_load   (shadow_load),
    .shadow_consume(shadow_consume),
    .arg_value     (arg_value),
    .fld_valid     (fld_valid),
    .fld_ready     (fld_ready),
    .fld_size      (fld_size),
    .fld_spec      (fld_spec),
    .fld_value     (fld_value),
    .fx_valid      (fx_valid),
    .fx_data       (fx_data),
    .fx_last       (fx_last),
    .fx_ready      (fx_ready),
    .out_valid     (out_valid),
    .out_data      (out_data),
    .out_ready     (out_ready),
    .busy          (busy),
    .done          (done)
  );

endmodule

// File: rtl/fmt_print_seq_chk.sv
module fmt_print_seq_chk #(
  parameter int unsigned SZ_W = 6,
  parameter int unsigned SP_W = 8,
  parameter int unsigned FV_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            en,
  input logic            fld_valid,
  input logic            fld_ready,
  input logic [SZ_W-1:0] fld_size,
  input logic [SP_W-1:0] fld_spec,
  input logic [FV_W-1:0] fld_value,
  input logic            fx_ready,
  input logic            out_valid,
  input logic [7:0]      out_data,
  input logic            out_ready,
  input logic            busy,
  input logic            done
);

  logic [FV_W:0] value_ext;
  assign value_ext = {1'b0, fld_value};

  // R6
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  // R8
  fld_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fld_valid && !fld_ready |=> fld_valid && $stable(fld_value)
                                && $stable(fld_size) && $stable(fld_spec));

  // R8
  fld_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fld_valid |-> ((value_ext >> fld_size) == '0));

  // R11
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && $past(busy));

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !out_valid && !fld_valid && !fx_ready);

  // R4
  start_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(en));

  // R9
  fx_only_stream_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fx_ready |-> busy && !fld_valid);

endmodule

bind fmt_print_seq fmt_print_seq_chk #(
  .SZ_W(SZ_W),
  .SP_W(SP_W),
  .FV_W(FV_W)
) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .en       (en),
  .fld_valid(fld_valid),
  .fld_ready(fld_ready),
  .fld_size (fld_size),
  .fld_spec (fld_spec),
  .fld_value(fld_value),
  .fx_ready (fx_ready),
  .out_valid(out_valid),
  .out_data (out_data),
  .out_ready(out_ready),
  .busy     (busy),
  .done     (done)
);

// File: tb/fmt_print_seq_tb_top.sv
module fmt_print_seq_tb_top;

  logic        clk;
  logic        rst_n;
  logic        en;
  logic [2:0]  trig;
  logic [63:0] args;
  logic [4:0]  fmt_addr;
  logic [1:0]  fmt_kind;
  logic [7:0]  fmt_char;
  logic [5:0]  fmt_size;
  logic [7:0]  fmt_spec;
  logic        fld_valid, fld_ready;
  logic [5:0]  fld_size;
  logic [7:0]  fld_spec;
  logic [31:0] fld_value;
  logic        fx_valid, fx_last, fx_ready;
  logic [7:0]  fx_data;
  logic        out_valid, out_ready;
  logic [7:0]  out_data;
  logic        busy, done;

  // program memory
  logic [1:0] pk [0:31];
  logic [7:0] pc [0:31];
  logic [5:0] ps [0:31];
  logic [7:0] pp [0:31];

  assign fmt_kind = pk[fmt_addr];
  assign fmt_char = pc[fmt_addr];
  assign fmt_size = ps[fmt_addr];
  assign fmt_spec = pp[fmt_addr];

  int n_chk  = 0;
  int n_fail = 0;

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  fmt_print_seq dut_i (
    .clk(clk), .rst_n(rst_n), .en(en), .trig(trig), .args(args),
    .fmt_addr(fmt_addr), .fmt_kind(fmt_kind), .fmt_char(fmt_char),
    .fmt_size(fmt_size), .fmt_spec(fmt_spec),
    .fld_valid(fld_valid), .fld_ready(fld_ready), .fld_size(fld_size),
    .fld_spec(fld_spec), .fld_value(fld_value),
    .fx_valid(fx_valid), .fx_data(fx_data), .fx_last(fx_last), .fx_ready(fx_ready),
    .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
    .busy(busy), .done(done)
  );

  // free-running instance: program "AB" then end
  logic        fr_en;
  logic [4:0]  fr_addr;
  logic [1:0]  fr_kind;
  logic [7:0]  fr_char;
  logic        fr_fv, fr_ov, fr_fxr, fr_busy, fr_done;
  logic [5:0]  fr_fs;
  logic [7:0]  fr_fp, fr_od;
  logic [31:0] fr_fval;

  assign fr_kind = (fr_addr < 5'd2) ? 2'd1 : 2'd0;
  assign fr_char = (fr_addr == 5'd0) ? 8'h41 : 8'h42;

  fmt_print_seq #(.TRG_EN(1'b0)) dut_free_i (
    .clk(clk), .rst_n(rst_n), .en(fr_en), .trig(3'b000), .args(64'd0),
    .fmt_addr(fr_addr), .fmt_kind(fr_kind), .fmt_char(fr_char),
    .fmt_size(6'd0), .fmt_spec(8'd0),
    .fld_valid(fr_fv), .fld_ready(1'b0), .fld_size(fr_fs),
    .fld_spec(fr_fp), .fld_value(fr_fval),
    .fx_valid(1'b0), .fx_data(8'd0), .fx_last(1'b0), .fx_ready(fr_fxr),
    .out_valid(fr_ov), .out_data(fr_od), .out_ready(1'b1),
    .busy(fr_busy), .done(fr_done)
  );

  function automatic logic [7:0] hexch(input logic [3:0] n);
    return (n < 4'd10) ? (8'h30 + 8'(n)) : (8'h57 + 8'(n));
  endfunction

  function automatic int ndig(input int sz);
    return (sz == 0) ? 1 : (sz + 3) / 4;
  endfunction

  // formatter model: hex digits, most significant first
  logic        fx_busy;
  logic [31:0] fx_val;
  logic [3:0]  fx_idx;
  logic [7:0]  fx_spec_seen;
  logic [5:0]  fx_size_seen;

  assign fx_valid = fx_busy;
  assign fx_last  = (fx_idx == 4'd0);
  assign fx_data  = hexch(4'(fx_val >> (4 * fx_idx)));

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fx_busy      <= 1'b0;
      fx_val       <= '0;
      fx_idx       <= '0;
      fld_ready    <= 1'b0;
      out_ready    <= 1'b0;
      fx_spec_seen <= '0;
      fx_size_seen <= '0;
    end else begin
      out_ready <= ($urandom % 4) != 0;
      fld_ready <= !(fx_busy || (fld_valid && fld_ready)) && (($urandom % 3) != 0);
      if (fld_valid && fld_ready) begin
        fx_busy      <= 1'b1;
        fx_val       <= fld_value;
        fx_idx       <= 4'(ndig(int'(fld_size)) - 1);
        fx_spec_seen <= fld_spec;
        fx_size_seen <= fld_size;
      end else if (fx_busy && fx_ready) begin
        if (fx_idx == 4'd0) fx_busy <= 1'b0;
        else                fx_idx  <= fx_idx - 4'd1;
      end
    end
  end

  // capture monitors
  logic [7:0] cap [0:511];
  int cap_n    = 0;
  int done_cnt = 0;
  int fr_bytes = 0;
  int fr_dones = 0;
  int fr_bad   = 0;
  logic [7:0] fr_prev = 8'h42;

  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid && out_ready) begin
        if (cap_n < 512) cap[cap_n] = out_data;
        cap_n++;
      end
      if (done) done_cnt++;
      if (fr_ov) begin
        fr_bytes++;
        if (fr_od == fr_prev) fr_bad++;
        fr_prev = fr_od;
      end
      if (fr_done) fr_dones++;
    end
  end

  logic [7:0] exp_s [0:511];
  int exp_n;

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic clr_prog();
    for (int i = 0; i < 32; i++) begin
      pk[i] = 2'd0; pc[i] = 8'd0; ps[i] = 6'd0; pp[i] = 8'd0;
    end
  endtask

  task automatic put_ch(input int i, input logic [7:0] c);
    pk[i] = 2'd1; pc[i] = c;
  endtask

  task automatic put_fd(input int i, input int sz, input logic [7:0] sp);
    pk[i] = 2'd2; ps[i] = 6'(sz); pp[i] = sp;
  endtask

  // expected text from R6..R11
  task automatic build_exp(input logic [63:0] a);
    logic [63:0] sh;
    logic [31:0] v;
    int i;
    int nd;
    sh = a;
    i = 0;
    exp_n = 0;
    while (i < 32) begin
      if (pk[i] == 2'd1) begin
        exp_s[exp_n] = pc[i]; exp_n++;
        i += (pc[i] == 8'h7B || pc[i] == 8'h7D) ? 2 : 1;
      end else if (pk[i] == 2'd2) begin
        if (ps[i] >= 6'd32) v = sh[31:0];
        else v = sh[31:0] & ((32'd1 << ps[i]) - 32'd1);
        sh = sh >> ps[i];
        nd = ndig(int'(ps[i]));
        for (int d = nd - 1; d >= 0; d--) begin
          exp_s[exp_n] = hexch(4'(v >> (4 * d))); exp_n++;
        end
        i++;
      end else begin
        break;
      end
    end
  endtask

  task automatic wait_done(input int base, input string req);
    int t;
    t = 0;
    while (done_cnt == base && t < 4000) begin
      tick(1);
      t++;
    end
    chk(done_cnt > base, {req, " print completes"}, 64'(done_cnt), 64'(base + 1));
  endtask

  task automatic cmp_text(input string req);
    int bad;
    bad = -1;
    chk(cap_n == exp_n, {req, " length"}, 64'(cap_n), 64'(exp_n));
    for (int i = 0; i < exp_n && i < cap_n; i++)
      if (bad < 0 && cap[i] != exp_s[i]) bad = i;
    if (bad >= 0) chk(1'b0, {req, " text"}, 64'(cap[bad]), 64'(exp_s[bad]));
    else          chk(1'b1, {req, " text"}, 64'd0, 64'd0);
  endtask

  task automatic fire_print(input logic [2:0] nt, input string req);
    int base;
    base  = done_cnt;
    cap_n = 0;
    trig  = nt;
    wait_done(base, req);
    tick(2);
    cmp_text(req);
  endtask

  task automatic no_fire(input logic [2:0] nt, input string req);
    int base;
    base  = done_cnt;
    cap_n = 0;
    trig  = nt;
    tick(6);
    chk(done_cnt == base && cap_n == 0 && !busy, req, 64'(cap_n), 64'd0);
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    summary();
    $finish;
  end

  initial begin
    logic [63:0] a0;
    int base;
    void'($urandom(32'd4242));
    rst_n = 1'b0; en = 1'b0; fr_en = 1'b0; trig = 3'b000; args = '0;
    clr_prog();
    tick(3);
    // R1 during reset
    chk(!busy && !out_valid && !fld_valid && !done, "R1 reset", 64'(busy), 64'd0);
    rst_n = 1'b1;
    tick(1);
    chk(!busy && !out_valid && !fld_valid && !done, "R1 after release", 64'(busy), 64'd0);

    // R2 rising on bit0, R6/R8/R9: "v=abc!"
    en = 1'b1;
    clr_prog();
    put_ch(0, 8'h76); put_ch(1, 8'h3D); put_fd(2, 12, 8'h5A); put_ch(3, 8'h21);
    args = 64'hFFFF_0000_1234_5ABC;
    exp_n = 6;
    exp_s[0] = 8'h76; exp_s[1] = 8'h3D; exp_s[2] = 8'h61; exp_s[3] = 8'h62;
    exp_s[4] = 8'h63; exp_s[5] = 8'h21;
    fire_print(3'b001, "R2 R6 R9 rising bit0");
    chk(fx_spec_seen == 8'h5A && fx_size_seen == 6'd12, "R8 field spec and size",
        {fx_spec_seen, 2'b0, fx_size_seen}, {8'h5A, 8'd12});

    // R2 opposite edges do nothing
    no_fire(3'b011, "R2 rising edge on falling-polarity bit1");
    no_fire(3'b010, "R2 falling edge on rising-polarity bit0");
    build_exp(args);
    fire_print(3'b000, "R2 falling bit1");

    // R2 busy rises at the first sampling edge
    trig = 3'b001;
    @(posedge clk); #1;
    chk(busy, "R2 busy timing", 64'(busy), 64'd1);
    wait_done(done_cnt, "R2 timing print");
    tick(2);

    // R4 enable low blocks
    en = 1'b0;
    no_fire(3'b000, "R4 en low falling bit0 setup");
    no_fire(3'b001, "R4 en low rising bit0");
    en = 1'b1;
    no_fire(3'b001, "R4 no edge after en high");

    // R7 braces: entries { { x } } -> "{x}"
    clr_prog();
    put_ch(0, 8'h7B); put_ch(1, 8'h7B); put_ch(2, 8'h78); put_ch(3, 8'h7D); put_ch(4, 8'h7D);
    exp_n = 3; exp_s[0] = 8'h7B; exp_s[1] = 8'h78; exp_s[2] = 8'h7D;
    trig = 3'b000; tick(2);
    fire_print(3'b100, "R7 doubled braces");

    // R8 LSB-first ordering: 4,8,3 bits -> "7/3c/5"
    clr_prog();
    put_fd(0, 4, 8'h01); put_ch(1, 8'h2F); put_fd(2, 8, 8'h02); put_ch(3, 8'h2F);
    put_fd(4, 3, 8'h03);
    args = {49'h1_2345_6789_ABCD, 3'b101, 8'h3C, 4'h7};
    exp_n = 6;
    exp_s[0] = 8'h37; exp_s[1] = 8'h2F; exp_s[2] = 8'h33; exp_s[3] = 8'h63;
    exp_s[4] = 8'h2F; exp_s[5] = 8'h35;
    trig = 3'b000; tick(2);
    fire_print(3'b100, "R8 field order");

    // R10 and R5: args change and extra edges while busy
    clr_prog();
    for (int i = 0; i < 12; i++) put_ch(i, 8'h61 + 8'(i));
    put_fd(12, 16, 8'h10); put_ch(13, 8'h2E); put_fd(14, 20, 8'h11);
    a0 = 64'h0000_0ABC_DE12_3456;
    args = a0;
    build_exp(a0);
    trig = 3'b000; tick(2);
    base = done_cnt;
    cap_n = 0;
    trig = 3'b100;
    tick(1);
    args = {$urandom, $urandom};
    trig = 3'b101;
    tick(1);
    trig = 3'b100;
    tick(1);
    trig = 3'b101;
    args = ~a0;
    wait_done(base, "R10 print");
    tick(10);
    chk(done_cnt == base + 1, "R5 edges while busy dropped", 64'(done_cnt - base), 64'd1);
    cmp_text("R10 shadow args");

    // R11 no end entry: 32 literals then stop
    clr_prog();
    for (int i = 0; i < 32; i++) put_ch(i, 8'h41 + 8'(i % 26));
    build_exp(args);
    chk(exp_n == 32, "R11 expected length", 64'(exp_n), 64'd32);
    trig = 3'b000; tick(2);
    fire_print(3'b100, "R11 runs off the end");

    // R11 stop code 3 ends the print too
    clr_prog();
    put_ch(0, 8'h5A); pk[1] = 2'd3; put_ch(2, 8'h59);
    exp_n = 1; exp_s[0] = 8'h5A;
    trig = 3'b000; tick(2);
    fire_print(3'b100, "R11 kind 3 ends");

    // random programs
    for (int it = 0; it < 24; it++) begin
      int i;
      int len;
      clr_prog();
      len = 4 + int'($urandom % 26);
      i = 0;
      while (i < len && i < 31) begin
        int r;
        r = int'($urandom % 4);
        if (r == 0) begin
          put_fd(i, 1 + int'($urandom % 32), 8'($urandom));
          i++;
        end else if (r == 1) begin
          logic [7:0] b;
          b = ($urandom % 2) ? 8'h7B : 8'h7D;
          put_ch(i, b); put_ch(i + 1, b);
          i += 2;
        end else begin
          logic [7:0] c;
          c = 8'h20 + 8'($urandom % 95);
          if (c == 8'h7B || c == 8'h7D) c = 8'h2A;
          put_ch(i, c);
          i++;
        end
      end
      args = {$urandom, $urandom};
      build_exp(args);
      trig = 3'b000; tick(2);
      fire_print(3'b100, "R6 R7 R8 R9 random program");
    end

    // R3 free-running instance
    fr_en = 1'b1;
    tick(60);
    chk(fr_dones >= 8, "R3 repeated prints", 64'(fr_dones), 64'd8);
    chk(fr_bytes >= 16 && fr_bad == 0, "R3 alternating text", 64'(fr_bad), 64'd0);
    fr_en = 1'b0;
    tick(10);
    fr_bytes = 0;
    fr_dones = 0;
    tick(20);
    chk(fr_bytes == 0 && fr_dones == 0, "R4 free mode en low", 64'(fr_bytes), 64'd0);

    summary();
    $finish;
  end

endmodule